// File: doc/BRIEF.md
# Parallel ADC conversion and power controller

This block sits on the host side of a 16-bit sampling converter that has a parallel output bus. It drives the converter's active-low start line, chip-select line, output-enable line and run/shutdown line. It also watches the converter's idle status line, which is low for the whole of a conversion. When a request arrives, the controller selects the converter and waits a setup interval. It then gives a short low pulse on the start line and waits for the synchronised status line to rise again. One cycle after that rising edge it latches the data bus and presents the result with a one-cycle valid strobe. If the status line does not rise within a bounded time, the controller sets a sticky error flag and returns to idle.

Power-down is requested with a level input. While it is held, the run line is low. The chip-select level tells the converter which power-down depth to use: low means the light nap state and high means the deep sleep state. The depth is taken from a mode input when shutdown begins. When the request is released, the controller keeps its ready output low for a wake-up wait whose length depends on the depth that was used. Any conversion request made during shutdown or during the wake-up wait is refused and reported with a one-cycle pulse.

The sequencing is a state machine with seven states:

- IDLE: ready, with all lines inactive.
- SETUP: select held ahead of the start edge.
- PULSE: start line low.
- WAIT: waiting for the status line to rise, or for the time limit.
- LATCH: capture of the data bus.
- DOWN: shutdown.
- WAKE: wake-up wait.

Transitions:

- IDLE to DOWN on a power-down request. This has priority over a conversion request in the same cycle.
- IDLE to SETUP on a conversion request.
- SETUP to PULSE when the setup count ends.
- PULSE to WAIT when the pulse count ends.
- WAIT to LATCH on the synchronised rising edge of the status line.
- WAIT to IDLE when the time limit expires.
- LATCH to IDLE.
- DOWN to WAKE when the power-down request is released.
- WAKE to IDLE when the wake-up count ends.

Top module: `pconv_ctrl`

## Requirements
- R1: After reset, these lines are high (inactive): adc_start_n, adc_sel_n, adc_oe_n and adc_run. The outputs result, result_vld, rejected and timeout_err are 0, and ready is 1. Reset also clears timeout_err after it has been set.
- R2: A start_req sampled in IDLE without pd_req drives adc_sel_n and adc_oe_n low and ready low from the next cycle. adc_start_n falls exactly SEL_SETUP cycles after adc_sel_n falls. adc_sel_n stays low until the result is latched.
- R3: adc_start_n stays low for exactly START_LOW cycles per conversion and then returns high. Elaboration fails if START_LOW times CLK_NS is 500 or more.
- R4: adc_idle_i passes through SYNC_STAGES flip-flops before its rising edge is detected. adc_data_i is latched in the cycle after that edge. result_vld is high for one cycle in the cycle after that, with result holding the latched bus value. In that same cycle adc_sel_n is high and ready is 1. With the default two stages, result_vld appears SEL_SETUP+5+C cycles after the request is sampled, where C is the number of cycles adc_idle_i is low.
- R5: Only one start pulse is issued per request. A start_req arriving while a conversion is in progress is ignored, with no second pulse and no rejected pulse.
- R6: If the synchronised rising edge is not seen within CONV_MAX cycles of entering WAIT, timeout_err is set SEL_SETUP+START_LOW+CONV_MAX cycles after the request, no result_vld follows, and the controller returns to IDLE. A rising edge in the last counted cycle still wins. timeout_err stays set until reset, including across later successful conversions.
- R7: While pd_req is held, adc_run is low and adc_start_n is high. adc_sel_n is low for nap (pd_deep=0) and high for sleep (pd_deep=1). The depth is taken from pd_deep when shutdown begins, and later changes of pd_deep do not affect it.
- R8: After pd_req is released, adc_run and adc_sel_n go high. ready then rises exactly NAP_WAIT cycles (nap) or SLEEP_WAIT cycles (sleep) after the cycle in which the release was sampled.
- R9: A start_req sampled in DOWN, in WAKE, or in IDLE together with pd_req starts no conversion. It gives rejected=1 for exactly one cycle, in the cycle after it was sampled.
- R10: A pd_req raised during a conversion is deferred. The result is still delivered on time, and adc_run falls one cycle after result_vld.
- R11: ready is 1 only in IDLE. Whenever ready is 1, adc_run, adc_sel_n and adc_start_n are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Conversion request, sampled each cycle |
| pd_req | input | 1 | Power-down request, level |
| pd_deep | input | 1 | Power-down depth: 0 nap, 1 sleep, taken when shutdown begins |
| adc_idle_i | input | 1 | Converter status, low while converting |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| adc_start_n | output | 1 | Conversion start, falling edge starts |
| adc_sel_n | output | 1 | Chip select, active low; encodes depth during shutdown |
| adc_oe_n | output | 1 | Output enable, active low |
| adc_run | output | 1 | High to run, low for shutdown |
| result | output | DATA_W | Last latched conversion result |
| result_vld | output | 1 | One-cycle strobe for result |
| ready | output | 1 | High when a request would be accepted |
| rejected | output | 1 | One-cycle pulse for a refused request |
| timeout_err | output | 1 | Sticky conversion time-limit error |

## Verification
The bench builds the controller with these parameters: SEL_SETUP=2, START_LOW=5, NAP_WAIT=8, SLEEP_WAIT=40 and CONV_MAX=30, with CLK_NS=4. A behavioural converter model keeps its status line low for a chosen number of cycles. Because the windows are this short, the bench can sweep the conversion length over every value from 6 up to the last one that still completes, which is 31. It then tries 32, the first value that times out, and so covers both sides of the time-limit boundary. The short wake-up waits let each nap and sleep wait be measured to the exact cycle, together with rejection at each refusing state and a change of depth while in shutdown.

// File: rtl/pconv_pkg.sv
package pconv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_WAIT,
        ST_LATCH,
        ST_DOWN,
        ST_WAKE
    } pconv_state_e;

    // States in which the converter is selected for a conversion
    function automatic logic in_conversion(pconv_state_e s);
        return (s == ST_SETUP) || (s == ST_PULSE) || (s == ST_WAIT) || (s == ST_LATCH);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pconv_sync.sv
module pconv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= {(STAGES + 1){RST_VAL}};
        end else begin
            sh <= {sh[STAGES-1:0], d};
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/pconv_timer.sv
module pconv_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/pconv_ctrl.sv
module pconv_ctrl
    import pconv_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CLK_NS      = 10,
    parameter int SEL_SETUP   = 2,
    parameter int START_LOW   = 20,
    parameter int NAP_WAIT    = 100,
    parameter int SLEEP_WAIT  = 16_000_000,
    parameter int CONV_MAX    = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              pd_req,
    input  logic              pd_deep,
    input  logic              adc_idle_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              adc_start_n,
    output logic              adc_sel_n,
    output logic              adc_oe_n,
    output logic              adc_run,
    output logic [DATA_W-1:0] result,
    output logic              result_vld,
    output logic              ready,
    output logic              rejected,
    output logic              timeout_err
);
    localparam int LONGEST = max_of(max_of(SEL_SETUP, START_LOW),
                                    max_of(max_of(NAP_WAIT, SLEEP_WAIT), CONV_MAX));
    localparam int TW = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] LD_SETUP = TW'(SEL_SETUP - 1);
    localparam logic [TW-1:0] LD_PULSE = TW'(START_LOW - 1);
    localparam logic [TW-1:0] LD_CONV  = TW'(CONV_MAX - 1);
    localparam logic [TW-1:0] LD_NAP   = TW'(NAP_WAIT - 1);
    localparam logic [TW-1:0] LD_SLEEP = TW'(SLEEP_WAIT - 1);

    // Elaboration-time parameter checks
    if (START_LOW * CLK_NS >= 500) begin : g_pulse_too_wide
        $error("start pulse of %0d ns must stay below 500 ns", START_LOW * CLK_NS);
    end
    if (START_LOW < 1) begin : g_pulse_empty
        $error("START_LOW must be at least 1");
    end
    if (SEL_SETUP < 2) begin : g_setup_short
        $error("SEL_SETUP must be at least 2");
    end
    if (NAP_WAIT < 1 || SLEEP_WAIT < 1 || CONV_MAX < 1) begin : g_wait_empty
        $error("wait counts must be at least 1");
    end
    if (SYNC_STAGES < 2) begin : g_sync_short
        $error("SYNC_STAGES must be at least 2");
    end

    pconv_state_e  state, nxt;
    logic          mode_deep, mode_nxt;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          idle_rise;
    logic          rej_nxt;
    logic          conv_expired;

    pconv_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) i_idle_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (adc_idle_i),
        .rise (idle_rise)
    );

    pconv_timer #(
        .W(TW)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    assign conv_expired = (state == ST_WAIT) && !idle_rise && tmr_zero;
    assign mode_nxt     = (state == ST_IDLE && nxt == ST_DOWN) ? pd_deep : mode_deep;

    // Next-state decision
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rej_nxt  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pd_req) begin
                    nxt     = ST_DOWN;
                    rej_nxt = start_req;
                end else if (start_req) begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    nxt      = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    nxt      = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_CONV;
                end
            end
            ST_WAIT: begin
                if (idle_rise) begin
                    nxt = ST_LATCH;
                end else if (tmr_zero) begin
                    nxt = ST_IDLE;
                end
            end
            ST_LATCH: begin
                nxt = ST_IDLE;
            end
            ST_DOWN: begin
                rej_nxt = start_req;
                if (!pd_req) begin
                    nxt      = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = mode_deep ? LD_SLEEP : LD_NAP;
                end
            end
            ST_WAKE: begin
                rej_nxt = start_req;
                if (tmr_zero) begin
                    nxt = ST_IDLE;
                end
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_deep <= 1'b0;
        end else begin
            state     <= nxt;
            mode_deep <= mode_nxt;
        end
    end

    // Registered outputs, decoded from the next state so pins change with the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_start_n <= 1'b1;
            adc_sel_n   <= 1'b1;
            adc_oe_n    <= 1'b1;
            adc_run     <= 1'b1;
            ready       <= 1'b1;
            rejected    <= 1'b0;
            result_vld  <= 1'b0;
            result      <= '0;
            timeout_err <= 1'b0;
        end else begin
            adc_start_n <= (nxt != ST_PULSE);
            adc_oe_n    <= !in_conversion(nxt);
            adc_sel_n   <= !(in_conversion(nxt) || (nxt == ST_DOWN && !mode_nxt));
            adc_run     <= (nxt != ST_DOWN);
            ready       <= (nxt == ST_IDLE);
            rejected    <= rej_nxt;
            result_vld  <= (state == ST_LATCH);
            if (state == ST_LATCH) begin
                result <= adc_data_i;
            end
            if (conv_expired) begin
                timeout_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pconv_chk.sv
module pconv_chk #(
    parameter int START_LOW = 20
) (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic adc_idle_i,
    input logic adc_start_n,
    input logic adc_sel_n,
    input logic adc_run,
    input logic ready,
    input logic rejected,
    input logic result_vld,
    input logic timeout_err
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!adc_start_n) begin
            if (low_run != 16'hFFFF) begin
                low_run <= low_run + 16'd1;
            end
        end else begin
            low_run <= '0;
        end
    end

    // R2
    sel_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_start_n) |-> (!adc_sel_n && $past(!adc_sel_n, 1) && $past(!adc_sel_n, 2)));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start_n) |-> (low_run == 16'(START_LOW)));

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_start_n) |-> adc_idle_i);

    // R4
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);

    // R7
    shdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_run |-> (adc_start_n && !ready));

    // R7
    shdn_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_run && $past(!adc_run)) |-> $stable(adc_sel_n));

    // R9
    reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> ($past(start_req) && !ready));

    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (adc_run && adc_sel_n && adc_start_n));

endmodule

bind pconv_ctrl pconv_chk #(
    .START_LOW(START_LOW)
) i_pconv_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .adc_idle_i (adc_idle_i),
    .adc_start_n(adc_start_n),
    .adc_sel_n  (adc_sel_n),
    .adc_run    (adc_run),
    .ready      (ready),
    .rejected   (rejected),
    .result_vld (result_vld),
    .timeout_err(timeout_err)
);

// File: tb/test_pconv_ctrl.sv
module test_pconv_ctrl;
    localparam int DW         = 16;
    localparam int CLK_NS     = 4;
    localparam int SEL_SETUP  = 2;
    localparam int START_LOW  = 5;
    localparam int NAP_WAIT   = 8;
    localparam int SLEEP_WAIT = 40;
    localparam int CONV_MAX   = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic          pd_req = 1'b0;
    logic          pd_deep = 1'b0;
    logic          adc_idle;
    logic [DW-1:0] adc_data;
    logic          adc_start_n, adc_sel_n, adc_oe_n, adc_run;
    logic [DW-1:0] result;
    logic          result_vld, ready, rejected, timeout_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pconv_ctrl #(
        .DATA_W    (DW),
        .CLK_NS    (CLK_NS),
        .SEL_SETUP (SEL_SETUP),
        .START_LOW (START_LOW),
        .NAP_WAIT  (NAP_WAIT),
        .SLEEP_WAIT(SLEEP_WAIT),
        .CONV_MAX  (CONV_MAX)
    ) i_pconv_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .pd_req     (pd_req),
        .pd_deep    (pd_deep),
        .adc_idle_i (adc_idle),
        .adc_data_i (adc_data),
        .adc_start_n(adc_start_n),
        .adc_sel_n  (adc_sel_n),
        .adc_oe_n   (adc_oe_n),
        .adc_run    (adc_run),
        .result     (result),
        .result_vld (result_vld),
        .ready      (ready),
        .rejected   (rejected),
        .timeout_err(timeout_err)
    );

    // Behavioural converter: status low for conv_cycles after a selected falling start edge
    int            conv_cycles = 10;
    logic [DW-1:0] sample_val = '0;
    logic          m_idle = 1'b1;
    logic          m_start_d = 1'b1;
    int            m_cnt = 0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idle    <= 1'b1;
            m_start_d <= 1'b1;
            m_cnt     <= 0;
        end else begin
            m_start_d <= adc_start_n;
            if (m_start_d && !adc_start_n && !adc_sel_n && adc_run && m_idle) begin
                m_idle <= 1'b0;
                m_cnt  <= conv_cycles;
            end else if (!m_idle) begin
                if (m_cnt <= 1) begin
                    m_idle <= 1'b1;
                    m_data <= sample_val;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end
        end
    end

    assign adc_idle = m_idle;
    assign adc_data = (!adc_sel_n && !adc_oe_n) ? m_data : '0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One conversion request; observations indexed by cycles after the sampling edge
    task automatic run_conv(input int c, input logic [DW-1:0] val, input bit exp_to,
                            input bit poke_start, input bit poke_pd, input bit exp_err_end);
        int first_low = -1;
        int lows = 0;
        int falls = 0;
        int vld_at = -1;
        int err_at = -1;
        int down_at = -1;
        bit rej_seen = 1'b0;
        logic prev_start = 1'b1;
        logic [DW-1:0] got = '0;
        bit err_before;
        conv_cycles = c;
        sample_val  = val;
        err_before  = timeout_err;
        @(negedge clk);
        start_req = 1'b1;
        @(posedge clk);
        #1 start_req = 1'b0;
        for (int m = 0; m < 60; m++) begin
            @(negedge clk);
            if (m == 0) begin
                chk(!adc_sel_n && !adc_oe_n && !ready, "R2 select/oe low, ready low after request",
                    int'(adc_sel_n), 0);
            end
            if (!adc_start_n) begin
                lows++;
                if (first_low < 0) first_low = m;
            end
            if (prev_start && !adc_start_n) falls++;
            prev_start = adc_start_n;
            if (rejected) rej_seen = 1'b1;
            if (result_vld && vld_at < 0) begin
                vld_at = m;
                got    = result;
                chk(adc_sel_n && ready, "R4 deselected and ready with result_vld",
                    int'(adc_sel_n & ready), 1);
            end
            if (timeout_err && !err_before && err_at < 0) err_at = m;
            if (!adc_run && down_at < 0) down_at = m;
            if (poke_start) start_req = (m == SEL_SETUP + START_LOW + 1);
            if (poke_pd && m == 3) pd_req = 1'b1;
        end
        start_req = 1'b0;
        chk(first_low == SEL_SETUP, "R2 start edge after select setup", first_low, SEL_SETUP);
        chk(lows == START_LOW, "R3 start pulse width", lows, START_LOW);
        chk(falls == 1, "R5 single start pulse", falls, 1);
        chk(!rej_seen, "R5 no rejected pulse during conversion", int'(rej_seen), 0);
        if (exp_to) begin
            chk(err_at == SEL_SETUP + START_LOW + CONV_MAX, "R6 timeout cycle", err_at,
                SEL_SETUP + START_LOW + CONV_MAX);
            chk(vld_at < 0, "R6 no result after timeout", vld_at, -1);
            chk(ready == 1'b1, "R6 back to idle after timeout", int'(ready), 1);
        end else begin
            chk(vld_at == SEL_SETUP + 5 + c, "R4 result latency", vld_at, SEL_SETUP + 5 + c);
            chk(got == val, "R4 result value", int'(got), int'(val));
        end
        chk(timeout_err == exp_err_end, "R6 error flag at end", int'(timeout_err), int'(exp_err_end));
        if (poke_pd) begin
            chk(down_at == vld_at + 1, "R10 shutdown deferred until result", down_at, vld_at + 1);
        end
    endtask

    task automatic run_pd(input bit deep, input bit flip, input bit with_start);
        int wait_exp;
        int rdy_at = -1;
        bit sel_seen = 1'b0;
        wait_exp = deep ? SLEEP_WAIT : NAP_WAIT;
        @(negedge clk);
        pd_deep   = deep;
        pd_req    = 1'b1;
        start_req = with_start;
        @(negedge clk);
        start_req = 1'b0;
        chk(!adc_run && adc_start_n, "R7 shutdown asserted", int'(adc_run), 0);
        chk(adc_sel_n == deep, "R7 select encodes depth", int'(adc_sel_n), int'(deep));
        chk(!ready, "R11 not ready in shutdown", int'(ready), 0);
        chk(rejected == with_start, "R9 reject with simultaneous power-down", int'(rejected),
            int'(with_start));
        if (flip) pd_deep = !deep;
        repeat (3) @(negedge clk);
        chk(adc_sel_n == deep && !adc_run, "R7 depth held after pd_deep change", int'(adc_sel_n),
            int'(deep));
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        chk(rejected == 1'b1, "R9 reject in shutdown", int'(rejected), 1);
        @(negedge clk);
        chk(rejected == 1'b0, "R9 reject lasts one cycle", int'(rejected), 0);
        chk(adc_start_n && adc_sel_n == deep, "R9 no conversion from rejected request",
            int'(adc_start_n), 1);
        pd_req = 1'b0;
        @(posedge clk);
        #1;
        for (int m = 0; m < SLEEP_WAIT + 6; m++) begin
            @(negedge clk);
            if (m == 0) begin
                chk(adc_run && adc_sel_n, "R8 run and deselect on release", int'(adc_run & adc_sel_n), 1);
            end
            if (m == 3) begin
                chk(rejected == 1'b1, "R9 reject during wake-up", int'(rejected), 1);
                start_req = 1'b0;
            end
            if (m == 2) start_req = 1'b1;
            if (!adc_sel_n) sel_seen = 1'b1;
            if (ready && rdy_at < 0) rdy_at = m;
        end
        chk(rdy_at == wait_exp, "R8 wake-up wait length", rdy_at, wait_exp);
        chk(!sel_seen, "R9 no conversion during wake-up", int'(sel_seen), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(adc_start_n && adc_sel_n && adc_oe_n && adc_run, "R1 lines inactive in reset",
            int'({adc_start_n, adc_sel_n, adc_oe_n, adc_run}), 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && !result_vld && !rejected && !timeout_err && result == '0, "R1 outputs after reset",
            int'({ready, result_vld, rejected, timeout_err}), 8);

        for (int c = 6; c <= CONV_MAX + 1; c++) begin
            run_conv(c, DW'((c * 2731) ^ 16'hA5C3), 1'b0, (c % 5) == 0, 1'b0, 1'b0);
        end
        run_conv(CONV_MAX + 2, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b1);
        run_conv(12, 16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b1);
        do_reset();
        chk(!timeout_err && ready, "R1 reset clears error", int'(timeout_err), 0);

        run_pd(1'b0, 1'b0, 1'b0);
        run_pd(1'b1, 1'b0, 1'b0);
        run_pd(1'b0, 1'b1, 1'b1);
        run_pd(1'b1, 1'b1, 1'b0);

        pd_deep = 1'b0;
        run_conv(10, 16'h0F0F, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(!adc_run && !adc_sel_n, "R10 nap shutdown after deferred request", int'(adc_run), 0);
        @(negedge clk);
        pd_req = 1'b0;
        repeat (NAP_WAIT + 3) @(negedge clk);
        chk(ready, "R8 ready after deferred shutdown wake-up", int'(ready), 1);
        run_conv(7, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        run_conv(9, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule